// File: doc/BRIEF.md
# Slot Transmitter Mute Controller

This block sits in the transmit path of a frame-based serial audio link whose frames are divided into a fixed number of equal slots. For every bit-clock tick it puts one bit on the serial data line, most significant bit first, working through the slots of a frame in order. For each slot it picks one of three data sources: the live sample word, a replay of the word that slot carried earlier, or all zeros. It also decides whether the data line is actively driven or released to high impedance.

Muting is requested through `mute_req`, but the request is only taken up when a frame begins, so no frame is ever partly muted. When the frame holds more than two slots, muted slots carry zeros. When it holds two or fewer, the repeat setting chooses between zeros and a replay of each slot's last unmuted word. The line-release setting makes the output-enable follow the slot-active mask, so the line lets go right after the last bit of an active slot whenever the slot after it is inactive.

The transmitter flag, the release setting, the repeat setting and the slot count are captured only while the block is disabled.

Top module: `slot_tx_mute`

## Requirements
- R1: Each `bit_tick` with `enable` high advances one bit position, and the registered outputs change on that clock edge. A tick with `frame_start` high is bit 0 of slot 0. Bits of a slot go out MSB first, WORD_W bits per slot, and the slots follow in ascending order up to the latched slot count.
- R2: An active, unmuted slot s transmits `sample_words[s*WORD_W +: WORD_W]`, as sampled at that slot's first bit.
- R3: A slot whose bit in `slot_active` (bit s for slot s) is 0 transmits zero bits.
- R4: In a muted frame with a latched slot count above 2, every slot transmits zero bits whatever `mute_repeat` is.
- R5: In a muted frame with a latched slot count of 1 or 2 and latched repeat = 1, each active slot retransmits the last word it sent unmuted.
- R6: In a muted frame with latched repeat = 0, every slot transmits zero bits.
- R7: `mute_req` is sampled only on the frame-start tick. A change in the middle of a frame does not affect the rest of that frame.
- R8: With latched release = 0 and transmitter = 1, `sd_oe` is 1 after every tick, including ticks in inactive slots and ticks after the last slot.
- R9: With latched release = 1, `sd_oe` after a tick equals the active bit of the slot being sent. After the last slot of a frame it is 0.
- R10: `tx_mode`, `hiz_en`, `mute_repeat` and `slot_count` are captured while `enable` is low. Changing them while `enable` is high has no effect until the next enable.
- R11: With latched transmitter = 0, `sd_out` and `sd_oe` stay 0.
- R12: With `enable` low, or in reset, `sd_out` and `sd_oe` are 0 from the next edge on, and the per-slot replay words are cleared to zero.
- R13: Between ticks, `sd_out` and `sd_oe` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; configuration is captured while it is low |
| tx_mode | input | 1 | 1 selects transmitter operation |
| frame_start | input | 1 | Marks the tick that carries bit 0 of slot 0 |
| bit_tick | input | 1 | One-cycle bit-clock strobe |
| slot_count | input | $clog2(NSLOT+1) | Slots per frame, 1..NSLOT |
| slot_active | input | NSLOT | Per-slot active mask, bit s for slot s |
| sample_words | input | NSLOT*WORD_W | Sample word for each slot, slot s at bits s*WORD_W upward |
| mute_req | input | 1 | Mute request, taken at frame start |
| mute_repeat | input | 1 | 1 replays the previous words while muted |
| hiz_en | input | 1 | 1 releases the line during inactive slots |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Data line output-enable |

## Verification
On every cycle, the assertions check that the outputs hold between ticks, that a disabled block or a non-transmitter config is silent, that the latched configuration cannot move while enabled, that the line stays driven when release is off, and that a muted frame with more than two slots emits only zeros. The bench's sweeps are needed to show the rest: the exact MSB-first bit order across slots, replay of the previous frame's words, the frame-boundary timing of mute when the request flips mid-frame, the release pattern set by the active mask, and the clearing of replay words across a disable.

// File: rtl/stm_pkg.sv
package stm_pkg;
    // Source chosen for the word of the slot being sent
    typedef enum logic [1:0] {
        SRC_SAMPLE  = 2'd0,
        SRC_HISTORY = 2'd1,
        SRC_ZERO    = 2'd2
    } word_src_e;
endpackage

// File: rtl/stm_slot_timer.sv
module stm_slot_timer #(
    parameter int NSLOT  = 4,
    parameter int WORD_W = 8,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              fs_tick,
    input  logic [CNT_W-1:0]  slot_count,
    output logic              cur_valid,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    pos_t pos_q, pos_d, cur;

    always_comb begin
        // position served by the present tick
        cur = pos_q;
        if (fs_tick) begin
            cur.valid = 1'b1;
            cur.slot  = '0;
            cur.bitn  = '0;
        end
        pos_d = pos_q;
        if (!run) begin
            pos_d = '0;
        end else if (tick) begin
            pos_d = cur;
            if (cur.valid) begin
                if (cur.bitn == LAST_BIT) begin
                    pos_d.bitn = '0;
                    if ((CNT_W'(cur.slot) + CNT_W'(1)) >= slot_count) begin
                        pos_d.valid = 1'b0;
                    end else begin
                        pos_d.slot = cur.slot + SLOT_W'(1);
                    end
                end else begin
                    pos_d.bitn = cur.bitn + BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign cur_valid = cur.valid;
    assign cur_slot  = cur.slot;
    assign cur_bit   = cur.bitn;
endmodule

// File: rtl/stm_word_src.sv
module stm_word_src (
    input  logic                   muted,
    input  logic                   repeat_en,
    input  logic                   many_slots,
    input  logic                   active,
    output stm_pkg::word_src_e     src
);
    import stm_pkg::*;

    always_comb begin
        if (!active)                       src = SRC_ZERO;
        else if (!muted)                   src = SRC_SAMPLE;
        else if (many_slots || !repeat_en) src = SRC_ZERO;
        else                               src = SRC_HISTORY;
    end
endmodule

// File: rtl/slot_tx_mute.sv
module slot_tx_mute #(
    parameter int NSLOT  = 4,
    parameter int WORD_W = 8,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      tx_mode,
    input  logic                      frame_start,
    input  logic                      bit_tick,
    input  logic [CNT_W-1:0]          slot_count,
    input  logic [NSLOT-1:0]          slot_active,
    input  logic [NSLOT*WORD_W-1:0]   sample_words,
    input  logic                      mute_req,
    input  logic                      mute_repeat,
    input  logic                      hiz_en,
    output logic                      sd_out,
    output logic                      sd_oe
);
    import stm_pkg::*;

    // largest slot count for which muted slots may replay old words
    localparam logic [CNT_W-1:0] REPLAY_MAX = CNT_W'(2);

    typedef struct packed {
        logic                          cfg_tx;
        logic                          cfg_hiz;
        logic                          cfg_rep;
        logic [CNT_W-1:0]              cfg_cnt;
        logic                          mute;
        logic [NSLOT-1:0][WORD_W-1:0]  hist;
        logic [WORD_W-1:0]             sh;
        logic                          sd;
        logic                          oe;
    } st_t;

    st_t st_q, st_d;

    logic [WORD_W-1:0] samp [NSLOT];
    logic              tick, fs_tick, mute_now, cur_act, many_slots;
    logic              cur_valid;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;
    logic [CNT_W-1:0]  cnt_clamped;
    logic [WORD_W-1:0] word;
    word_src_e         src;

    for (genvar s = 0; s < NSLOT; s++) begin : g_samp
        assign samp[s] = sample_words[s*WORD_W +: WORD_W];
    end

    assign tick       = enable & bit_tick;
    assign fs_tick    = tick & frame_start;
    assign mute_now   = fs_tick ? mute_req : st_q.mute;
    assign cur_act    = cur_valid & slot_active[cur_slot];
    assign many_slots = st_q.cfg_cnt > REPLAY_MAX;

    // out-of-range slot counts fold into 1..NSLOT
    always_comb begin
        if (slot_count == '0)                  cnt_clamped = CNT_W'(1);
        else if (slot_count > CNT_W'(NSLOT))   cnt_clamped = CNT_W'(NSLOT);
        else                                   cnt_clamped = slot_count;
    end

    stm_slot_timer #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .tick       (tick),
        .fs_tick    (fs_tick),
        .slot_count (st_q.cfg_cnt),
        .cur_valid  (cur_valid),
        .cur_slot   (cur_slot),
        .cur_bit    (cur_bit)
    );

    stm_word_src u_src (
        .muted      (mute_now),
        .repeat_en  (st_q.cfg_rep),
        .many_slots (many_slots),
        .active     (cur_act),
        .src        (src)
    );

    always_comb begin
        case (src)
            SRC_SAMPLE:  word = samp[cur_slot];
            SRC_HISTORY: word = st_q.hist[cur_slot];
            default:     word = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cfg_tx  = tx_mode;
            st_d.cfg_hiz = hiz_en;
            st_d.cfg_rep = mute_repeat;
            st_d.cfg_cnt = cnt_clamped;
            st_d.mute    = 1'b0;
            st_d.hist    = '0;
            st_d.sh      = '0;
            st_d.sd      = 1'b0;
            st_d.oe      = 1'b0;
        end else if (tick) begin
            st_d.mute = mute_now;
            if (cur_valid) begin
                if (cur_bit == '0) begin
                    st_d.sd = word[WORD_W-1];
                    st_d.sh = word << 1;
                    if (src == SRC_SAMPLE) st_d.hist[cur_slot] = samp[cur_slot];
                end else begin
                    st_d.sd = st_q.sh[WORD_W-1];
                    st_d.sh = st_q.sh << 1;
                end
                st_d.oe = st_q.cfg_tx & (st_q.cfg_hiz ? cur_act : 1'b1);
            end else begin
                st_d.sd = 1'b0;
                st_d.oe = st_q.cfg_tx & ~st_q.cfg_hiz;
            end
            st_d.sd = st_d.sd & st_q.cfg_tx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg_cnt <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_out = st_q.sd;
    assign sd_oe  = st_q.oe;

    // signals brought out for the bound checker
    logic chk_tx, chk_hiz, chk_rep, chk_many, chk_mute_now;
    assign chk_tx       = st_q.cfg_tx;
    assign chk_hiz      = st_q.cfg_hiz;
    assign chk_rep      = st_q.cfg_rep;
    assign chk_many     = many_slots;
    assign chk_mute_now = mute_now;
endmodule

// File: rtl/stm_tx_mute_chk.sv
module stm_tx_mute_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic bit_tick,
    input logic sd_out,
    input logic sd_oe,
    input logic cfg_tx,
    input logic cfg_hiz,
    input logic cfg_rep,
    input logic many_slots,
    input logic mute_now
);
    p_hold_between_ticks_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_tick) |=> ($stable(sd_out) && $stable(sd_oe)));

    p_off_when_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sd_out && !sd_oe));

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(cfg_tx) && $stable(cfg_hiz) && $stable(cfg_rep)));

    p_quiet_not_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx |=> (!sd_out && !sd_oe));

    p_driven_no_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_tick && cfg_tx && !cfg_hiz) |=> sd_oe);

    p_zero_many_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_tick && mute_now && many_slots) |=> !sd_out);
endmodule

bind slot_tx_mute stm_tx_mute_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .bit_tick   (bit_tick),
    .sd_out     (sd_out),
    .sd_oe      (sd_oe),
    .cfg_tx     (chk_tx),
    .cfg_hiz    (chk_hiz),
    .cfg_rep    (chk_rep),
    .many_slots (chk_many),
    .mute_now   (chk_mute_now)
);

// File: tb/slot_tx_mute_bench.sv
module slot_tx_mute_bench;
    localparam int NSLOT  = 4;
    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(NSLOT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, tx_mode = 1'b0, frame_start = 1'b0, bit_tick = 1'b0;
    logic [CNT_W-1:0] slot_count = CNT_W'(1);
    logic [NSLOT-1:0] slot_active = '0;
    logic [NSLOT*WORD_W-1:0] sample_words = '0;
    logic mute_req = 1'b0, mute_repeat = 1'b0, hiz_en = 1'b0;
    logic sd_out, sd_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    slot_tx_mute #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_slot_tx_mute (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode),
        .frame_start(frame_start), .bit_tick(bit_tick), .slot_count(slot_count),
        .slot_active(slot_active), .sample_words(sample_words),
        .mute_req(mute_req), .mute_repeat(mute_repeat), .hiz_en(hiz_en),
        .sd_out(sd_out), .sd_oe(sd_oe)
    );

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0b exp=%0b", tag, what, got, exp);
        end
    endtask

    // one tick: strobe for a cycle, sample after the edge, then again a cycle later
    task automatic do_tick(input logic fs, input logic exp_sd, input logic exp_oe,
                           input string tag_sd, input string tag_oe);
        logic s0, o0;
        @(negedge clk);
        bit_tick = 1'b1;
        frame_start = fs;
        @(negedge clk);
        bit_tick = 1'b0;
        frame_start = 1'b0;
        check(tag_sd, "sd_out", sd_out, exp_sd);
        check(tag_oe, "sd_oe", sd_oe, exp_oe);
        s0 = sd_out;
        o0 = sd_oe;
        @(negedge clk);
        check("R13", "sd_out hold", sd_out, s0);
        check("R13", "sd_oe hold", sd_oe, o0);
    endtask

    task automatic run_config(input int sc, input bit rep, input bit hiz, input bit tx,
                              input logic [NSLOT-1:0] mask);
        logic [WORD_W-1:0] bhist [NSLOT];
        logic [3:0] pat;
        @(negedge clk);
        enable = 1'b0;
        tx_mode = tx;
        hiz_en = hiz;
        mute_repeat = rep;
        slot_count = CNT_W'(sc);
        slot_active = mask;
        @(negedge clk);
        @(negedge clk);
        check("R12", "sd_out disabled", sd_out, 1'b0);
        check("R12", "sd_oe disabled", sd_oe, 1'b0);
        enable = 1'b1;
        // R10: these changes must not reach the running block
        tx_mode = ~tx;
        hiz_en = ~hiz;
        mute_repeat = ~rep;
        slot_count = CNT_W'((sc % NSLOT) + 1);
        for (int i = 0; i < NSLOT; i++) bhist[i] = '0;
        pat = rep ? 4'b1101 : 4'b0110;  // bit f = mute of frame f
        for (int f = 0; f < 4; f++) begin
            bit m;
            m = pat[f];
            mute_req = m;
            for (int s = 0; s < NSLOT; s++)
                sample_words[s*WORD_W +: WORD_W] = WORD_W'(f*37 + s*71 + sc*5 + rep*3 + 13);
            for (int s = 0; s < sc; s++) begin
                logic [WORD_W-1:0] w;
                logic act;
                act = mask[s];
                if (!act)                  w = '0;
                else if (!m)               w = sample_words[s*WORD_W +: WORD_W];
                else if (sc > 2 || !rep)   w = '0;
                else                       w = bhist[s];
                if (act && !m) bhist[s] = sample_words[s*WORD_W +: WORD_W];
                for (int b = 0; b < WORD_W; b++) begin
                    string tsd, toe;
                    if (s == 0 && b == 1) mute_req = ~m;  // R7: mid-frame flip
                    if (!tx)                               tsd = "R11";
                    else if (f == 0 && m && rep && sc <= 2) tsd = "R12";
                    else if (m)      tsd = (sc > 2) ? "R4" : (rep ? "R5" : "R6");
                    else if (!act)   tsd = "R3";
                    else if (b == 0) tsd = "R1";
                    else if (s > 0)  tsd = "R7";
                    else             tsd = "R2";
                    toe = !tx ? "R11" : (hiz ? "R9" : "R8");
                    do_tick(s == 0 && b == 0, tx & w[WORD_W-1-b],
                            tx & (hiz ? act : 1'b1), tsd, toe);
                end
            end
            // ticks after the last slot of the frame
            for (int k = 0; k < 2; k++)
                do_tick(1'b0, 1'b0, tx & ~hiz, "R1", "R10");
        end
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "sd_out in reset", sd_out, 1'b0);
        check("R12", "sd_oe in reset", sd_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "sd_out after reset", sd_out, 1'b0);
        check("R12", "sd_oe after reset", sd_oe, 1'b0);
        for (int sc = 1; sc <= NSLOT; sc++)
            for (int rep = 0; rep < 2; rep++)
                for (int hiz = 0; hiz < 2; hiz++) begin
                    logic [7:0] rot;
                    rot = 8'b1101_1101 >> (rep + 2*hiz);
                    run_config(sc, rep[0], hiz[0], 1'b1, rot[NSLOT-1:0]);
                end
        run_config(2, 1'b1, 1'b0, 1'b0, 4'b0011);
        run_config(3, 1'b0, 1'b1, 1'b0, 4'b0101);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule